// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

This block is a synchronous single-port memory whose reads are pipelined through an output register. Its writes follow a late-write protocol. On every rising clock edge it captures the address, an active-low select, an active-low global write enable, active-low per-byte write enables and a sleep input. Read data appears one clock after the read command. Write data is presented one clock after its write command, so the bus never needs a dead cycle between a read and a following write.

A write is not put into the array at once. Its address, byte mask and data wait in a one-entry write buffer. The buffer is committed to the array at the next write cycle, when it is replaced by that write. Every read compares its address with the buffered address. On a hit, the bytes named by the buffered mask come from the buffer and the other bytes come from the array. A read therefore always returns the most recent data.

An asynchronous active-low output enable gates the data output at any time. Whenever the output is not driven, a valid flag shows the high-impedance state and the data bus reads as zero.

Top module: `lwsram_core`

## Requirements
- R1: A read (select low, write enable high, sleep low) captured at clock edge n drives `dataOutValid` high and the word on `dataOut` after edge n+1. This holds while `oeN` is low.
- R2: The data of a write captured at edge n is taken from `dataIn` at edge n+1. The value of `dataIn` at any other edge is ignored.
- R3: A buffered write stays readable, however many non-write cycles follow it. Once a later write commits it to the array, reads of that address return the committed value.
- R4: A read whose address matches the pending buffered write returns the buffered bytes for that write's enabled bytes and the array bytes for all others.
- R5: A write (select low, write enable low) updates byte i, meaning bits [9i+8:9i], only when `byteWrN[i]` is 0. All enables at 0 writes the whole word.
- R6: A write with every `byteWrN` bit at 1 is aborted. It changes no byte, it leaves the pending buffered write in place, and the output is not driven in the following cycle.
- R7: Select high is a deselect. It changes no stored data, whatever the write controls are, and the output is not driven in the following cycle.
- R8: While `sleepIn` is high at an edge, the select and write controls are ignored, the array contents are kept, and the output is not driven in the following cycle.
- R9: `oeN` high forces `dataOutValid` low at once, even when a read result is waiting. While `dataOutValid` is low, `dataOut` is all zeros. Lowering `oeN` shows the held read word again.
- R10: A write cycle is followed by an undriven output cycle.
- R11: During and directly after reset the output is not driven, and the write buffer holds no pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | Word address |
| selN | input | 1 | Synchronous select, active low |
| wrN | input | 1 | Global write enable, active low |
| byteWrN | input | BYTES | Per-byte write enables, active low, bit i covers byte i |
| sleepIn | input | 1 | Synchronous sleep request, active high |
| oeN | input | 1 | Asynchronous output enable, active low |
| dataIn | input | BYTES*BYTE_W | Write data, one cycle after its write command |
| dataOut | output | BYTES*BYTE_W | Read data, zero when not driven |
| dataOutValid | output | 1 | High when the data output is driven |

## Verification
The assertions check the output-drive rules on every cycle. They cover the two-edge read timing gated by the output enable, the undriven cycle after every write, abort, deselect and sleep, the immediate effect of the output enable, and the zero bus while undriven. The data itself can only be shown by the bench scenarios: the late sampling of write data, the byte-by-byte merge from the pending buffer, a buffer that survives aborts and idle cycles, and commits into the array. The bench sweeps every byte-enable pattern over every address and checks each read against a word model that applies writes at once.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  // strobes handed from the control stage to the datapath
  typedef struct packed {
    logic rd;
    logic wr;
  } lwStrobe_t;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              wrN,
  input  logic [BYTES-1:0]  byteWrN,
  input  logic              sleepIn,
  input  logic [ADDR_W-1:0] addrIn,
  output lwStrobe_t         stb,
  output logic [ADDR_W-1:0] addrQ,
  output logic [BYTES-1:0]  maskQ
);
  logic live;
  logic anyByte;

  assign live    = !sleepIn && !selN;
  assign anyByte = (byteWrN != {BYTES{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb   <= '0;
      addrQ <= '0;
      maskQ <= '0;
    end else begin
      stb.rd <= live && wrN;
      stb.wr <= live && !wrN && anyByte;
      addrQ  <= addrIn;
      maskQ  <= ~byteWrN;
    end
  end
endmodule

// File: rtl/lwsram_dpath.sv
module lwsram_dpath
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lwStrobe_t               stb,
  input  logic [ADDR_W-1:0]       addrQ,
  input  logic [BYTES-1:0]        maskQ,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  input  logic                    oeN,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic                    dataOutValid
);
  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] bufAddr;
  logic [BYTES-1:0]  bufMask;
  logic [DATA_W-1:0] bufData;
  logic              bufValid;
  logic [DATA_W-1:0] outReg;
  logic              outEn;
  logic [DATA_W-1:0] memWord;
  logic [DATA_W-1:0] rdWord;
  logic              hit;

  assign memWord = mem[addrQ];
  assign hit     = bufValid && (bufAddr == addrQ);

  // byte-wise bypass from the pending write
  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    assign rdWord[g*BYTE_W +: BYTE_W] = (hit && bufMask[g]) ?
        bufData[g*BYTE_W +: BYTE_W] : memWord[g*BYTE_W +: BYTE_W];
  end

  // commit of the previous buffered write on the next write cycle
  always_ff @(posedge clk) begin
    if (stb.wr && bufValid) begin
      for (int i = 0; i < BYTES; i++) begin
        if (bufMask[i]) mem[bufAddr][i*BYTE_W +: BYTE_W] <= bufData[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufAddr  <= '0;
      bufMask  <= '0;
      bufData  <= '0;
      outEn    <= 1'b0;
      outReg   <= '0;
    end else begin
      if (stb.wr) begin
        bufValid <= 1'b1;
        bufAddr  <= addrQ;
        bufMask  <= maskQ;
        bufData  <= dataIn;
      end
      outEn <= stb.rd;
      if (stb.rd) outReg <= rdWord;
    end
  end

  assign dataOutValid = outEn && !oeN;
  assign dataOut      = dataOutValid ? outReg : '0;
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    selN,
  input  logic                    wrN,
  input  logic [BYTES-1:0]        byteWrN,
  input  logic                    sleepIn,
  input  logic                    oeN,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic                    dataOutValid
);
  lwStrobe_t         stb;
  logic [ADDR_W-1:0] addrQ;
  logic [BYTES-1:0]  maskQ;

  lwsram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .byteWrN(byteWrN),
    .sleepIn(sleepIn), .addrIn(addrIn), .stb(stb), .addrQ(addrQ), .maskQ(maskQ)
  );

  lwsram_dpath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addrQ(addrQ), .maskQ(maskQ),
    .dataIn(dataIn), .oeN(oeN), .dataOut(dataOut), .dataOutValid(dataOutValid)
  );
endmodule

// File: rtl/lwsram_core_chk.sv
module lwsram_core_chk #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    selN,
  input logic                    wrN,
  input logic                    sleepIn,
  input logic                    oeN,
  input logic [BYTES*BYTE_W-1:0] dataOut,
  input logic                    dataOutValid
);
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepIn && !selN && wrN) |=> ##1 (dataOutValid == !oeN)); // R1
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepIn && !selN && !wrN) |=> ##1 !dataOutValid); // R10
  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepIn && selN) |=> ##1 !dataOutValid); // R7
  AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |=> ##1 !dataOutValid); // R8
  AST_OE_FORCE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dataOutValid); // R9
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutValid |-> (dataOut == '0)); // R9
endmodule

bind lwsram_core lwsram_core_chk #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .sleepIn(sleepIn),
  .oeN(oeN), .dataOut(dataOut), .dataOutValid(dataOutValid)
);

// File: tb/lwsram_core_bench.sv
module lwsram_core_bench;
  localparam int ADDR_W = 4;
  localparam int BYTES  = 4;
  localparam int BYTE_W = 9;
  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic [ADDR_W-1:0] addrIn;
  logic              selN, wrN, sleepIn, oeN;
  logic [BYTES-1:0]  byteWrN;
  logic [DATA_W-1:0] dataIn, dataOut;
  logic              dataOutValid;

  lwsram_core #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_lwsram_core (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .selN(selN), .wrN(wrN),
    .byteWrN(byteWrN), .sleepIn(sleepIn), .oeN(oeN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  logic [DATA_W-1:0] mdl [DEPTH];
  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic expV = 1'b0;
  logic [DATA_W-1:0] expD = '0;
  string expTag = "R11 post-reset idle";
  logic pendW = 1'b0;
  logic [DATA_W-1:0] pendD = '0;

  function automatic logic [DATA_W-1:0] pat(input int a, input int salt);
    return (DATA_W'(a) * DATA_W'(40503)) ^ (DATA_W'(salt) << 11) ^ DATA_W'(36'h5A5A5A5A5) ^ DATA_W'(salt * 7);
  endfunction

  task automatic check(input string tag, input logic ev, input logic [DATA_W-1:0] ed);
    checks++;
    if (dataOutValid !== ev || dataOut !== ed) begin
      failures++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               tag, dataOutValid, dataOut, ev, ed);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [BYTES-1:0] b, input int a,
                      input logic [DATA_W-1:0] d, input logic z, input logic oe, input string tag);
    logic curV;
    logic [DATA_W-1:0] curD;
    logic newPend;
    @(negedge clk);
    selN = s; wrN = w; byteWrN = b; addrIn = a[ADDR_W-1:0]; sleepIn = z; oeN = oe;
    // R2: only the cycle after a write carries its data, all else is junk
    dataIn = pendW ? pendD : (~pendD ^ DATA_W'(36'h123456789));
    curV = 1'b0; curD = '0; newPend = 1'b0;
    if (!z && !s) begin
      if (w) begin
        curV = 1'b1; curD = mdl[a];
      end else if (b != {BYTES{1'b1}}) begin
        for (int i = 0; i < BYTES; i++)
          if (!b[i]) mdl[a][i*BYTE_W +: BYTE_W] = d[i*BYTE_W +: BYTE_W];
        newPend = 1'b1;
      end
    end
    pendW = newPend; pendD = d;
    @(posedge clk); #1;
    check(expTag, expV && !oe, (expV && !oe) ? expD : '0);
    if (oe && expV) begin
      oeN = 1'b0; #1;
      check({expTag, " R9 oe release"}, 1'b1, expD);
    end
    expV = curV; expD = curD; expTag = tag;
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, 1'b1, '1, a, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input int a, input logic [BYTES-1:0] b, input logic [DATA_W-1:0] d, input string tag);
    step(1'b0, 1'b0, b, a, d, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: valid=%0b data=%h expected valid=x data=x", dataOutValid, dataOut);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; selN = 1'b1; wrN = 1'b1; byteWrN = '1; sleepIn = 1'b0; oeN = 1'b0;
    addrIn = '0; dataIn = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 in reset", 1'b0, '0);
    @(negedge clk); rstN = 1'b1;

    // full-word fill and read-back
    for (int a = 0; a < DEPTH; a++) wr(a, '0, pat(a, 0), "R2 R5 R10 full write");
    for (int a = 0; a < DEPTH; a++) rd(a, "R1 R3 read back");

    // sweep every byte-enable pattern over every address
    for (int a = 0; a < DEPTH; a++) begin
      for (int m = 0; m < (1 << BYTES); m++) begin
        wr(a, BYTES'(m), pat(a, m + 1), (m == (1 << BYTES) - 1) ? "R6 R10 aborted write" : "R5 R10 byte write");
        rd(a, "R4 bypass merge");
        rd((a + 1) % DEPTH, "R3 other address");
      end
    end
    for (int a = 0; a < DEPTH; a++) rd(a, "R3 committed read");

    // abort keeps the pending buffer
    wr(3, '0, pat(3, 99), "R10 write before abort");
    wr(5, '1, pat(5, 77), "R6 abort");
    rd(3, "R6 buffer kept");
    rd(5, "R6 no change");

    // deselect and sleep ignore write controls
    step(1'b1, 1'b0, '0, 5, pat(5, 55), 1'b0, 1'b0, "R7 deselect with write");
    rd(5, "R7 unchanged");
    step(1'b0, 1'b0, '0, 6, pat(6, 66), 1'b1, 1'b0, "R8 sleep with write");
    step(1'b0, 1'b1, '1, 6, '0, 1'b1, 1'b0, "R8 sleep with read");
    rd(6, "R8 contents kept");

    // pending write survives many non-write cycles
    wr(9, 4'b1010, pat(9, 123), "R10 partial write");
    for (int k = 0; k < 10; k++) begin
      rd(k % 8, "R3 other reads");
      step(1'b1, 1'b1, '1, 0, '0, 1'b0, 1'b0, "R7 idle deselect");
    end
    rd(9, "R3 R4 long pending");

    // output enable
    rd(2, "R9 read under oe");
    step(1'b0, 1'b1, '1, 4, '0, 1'b0, 1'b1, "R9 oe high");
    step(1'b1, 1'b1, '1, 0, '0, 1'b0, 1'b0, "R7 flush");
    step(1'b1, 1'b1, '1, 0, '0, 1'b0, 1'b0, "R7 flush");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule